// File: doc/BRIEF.md
# Dimmable Lamp Ballast Mode Sequencer

This block is the mode controller of a dimmable fluorescent lamp ballast. It receives digitized comparator flags from the analog front end and steps the ballast through five modes. In lockout the half-bridge is off. In filament preheat the bridge runs and the peak current is regulated against a user-set level. In ignition the frequency sweeps toward resonance under a fixed peak-current limit. In dimming the phase loop regulates lamp power. The fault mode is latched. The block drives the bridge enable, the preheat timer reset, the choice of current reference, the over-current enable, the preheat regulation request and the ignition-detect threshold select.

Before the sequencer acts on a flag, the flag must hold the same value for two consecutive clocks, so a single-cycle glitch cannot move the mode. Ignition is declared through a two-step pattern. First the sensed current must rise above a high detection level, which arms the detector and lowers the threshold. Then the current must fall below that lower level. Over-current only causes a fault in the ignition and dimming modes.

Top module: `ballast_mode_seq`

## Requirements
- R1: Reset behaviour. While reset is low, and right after reset, the mode is lockout. The mode output is one-hot with these bit positions: bit0 lockout, bit1 preheat, bit2 ignition, bit3 dim, bit4 fault. Also right after reset: the bridge enable is 0, the timer reset is 1, the reference select is 0, the over-current enable is 0, the regulation request is 0 and the detect-low select is 0.
- R2: Lockout moves to preheat only when all four of these hold together: supply above the start level, bus good, shutdown below its low level, and no over-temperature.
- R3: From preheat, ignition or dim, any one of these returns the block to lockout: supply below the stop level, bus low, or shutdown high. This return takes priority over any fault condition seen in the same cycle.
- R4: Output decode by mode. The bridge enable is 1 in preheat, ignition and dim. The timer reset is 1 in lockout and fault. The reference select is 1 (user preheat level) in preheat, 2 (fixed peak limit) in ignition and dim, and 0 otherwise. The over-current enable is 1 in ignition and dim.
- R5: Preheat moves to ignition when the timer-expired flag is set. The peak-limit flag is ignored in preheat. The regulation request equals the above-preheat-reference flag while in preheat, and is 0 in every other mode.
- R6: In ignition, the peak-limit flag or the over-temperature flag moves the block to fault. This covers a lamp that fails to strike.
- R7: In ignition, the above-arm-level flag arms the detector, and the detect-low select output then reads 1. Once armed, the above-detect-level flag going low moves the block to dim. If the detector was never armed, the above-detect-level flag has no effect. The detector disarms whenever the mode is not ignition.
- R8: In dim, the peak-limit flag or the over-temperature flag moves the block to fault. Over-temperature in preheat also moves it to fault.
- R9: Fault is latched. Only supply below the stop level, or shutdown high, leaves fault, and the block goes to lockout. Every other flag, including bus low, has no effect in fault.
- R10: After leaving fault, the block restarts through lockout into preheat once the R2 conditions hold.
- R11: A flag is acted on only after it has held the same value for two consecutive clocks. A one-cycle pulse is ignored and a two-cycle pulse is accepted. A flag that changes just before a rising edge moves the mode on the fourth rising edge after the change.
- R12: The mode register is always one-hot. Any illegal encoding goes to lockout on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_start_i | input | 1 | Supply above start threshold |
| vcc_stop_i | input | 1 | Supply below stop threshold |
| bus_good_i | input | 1 | Bus sense above turn-on level |
| bus_low_i | input | 1 | Bus sense below turn-off level |
| sd_high_i | input | 1 | Shutdown input above its high threshold |
| sd_low_i | input | 1 | Shutdown input below its low threshold |
| over_temp_i | input | 1 | Junction over-temperature |
| cur_limit_i | input | 1 | Sensed current above fixed peak limit |
| cur_ph_i | input | 1 | Sensed current above user preheat reference |
| cur_arm_i | input | 1 | Sensed current above arm level (reference +20%) |
| cur_det_i | input | 1 | Sensed current above detect level (reference +10%) |
| tmr_done_i | input | 1 | Preheat timer expired |
| mode_o | output | 5 | One-hot mode |
| bridge_en_o | output | 1 | Half-bridge drive enable |
| timer_rst_o | output | 1 | Hold preheat timer reset |
| cur_ref_sel_o | output | 2 | Peak-current reference: 0 none, 1 preheat, 2 limit |
| ocp_en_o | output | 1 | Over-current fault enable |
| pk_raise_o | output | 1 | Preheat regulation request (raise frequency) |
| det_ref_low_o | output | 1 | Ignition detector armed, lower threshold selected |

## Verification
The assertions assume that paired flags stay mutually consistent, and the stimulus is built to respect this. Supply above start is never set together with supply below stop, bus good never together with bus low, and shutdown high never together with shutdown low. The above-detect-level flag is set whenever the above-arm-level flag is set, because the arm level sits above the detect level. All stimulus rows are held for many cycles, so every flag passes the stability filter, except for the pulses that deliberately probe it. The filter assertion relates each change of a filtered flag to the raw flag history and needs no assumption on the inputs.

// File: rtl/bms_pkg.sv
package bms_pkg;
  // Flag vector layout
  localparam int NUM_FLAGS    = 12;
  localparam int FL_VCC_START = 0;
  localparam int FL_VCC_STOP  = 1;
  localparam int FL_BUS_GOOD  = 2;
  localparam int FL_BUS_LOW   = 3;
  localparam int FL_SD_HIGH   = 4;
  localparam int FL_SD_LOW    = 5;
  localparam int FL_OVER_TEMP = 6;
  localparam int FL_CUR_LIMIT = 7;
  localparam int FL_CUR_PH    = 8;
  localparam int FL_CUR_ARM   = 9;
  localparam int FL_CUR_DET   = 10;
  localparam int FL_TMR_DONE  = 11;

  // One-hot mode bit positions
  localparam int NUM_MODES = 5;
  localparam int MB_LOCK   = 0;
  localparam int MB_PH     = 1;
  localparam int MB_IGN    = 2;
  localparam int MB_DIM    = 3;
  localparam int MB_FAULT  = 4;

  typedef logic [NUM_MODES-1:0] mode_t;

  localparam mode_t MODE_LOCK  = mode_t'(1) << MB_LOCK;
  localparam mode_t MODE_PH    = mode_t'(1) << MB_PH;
  localparam mode_t MODE_IGN   = mode_t'(1) << MB_IGN;
  localparam mode_t MODE_DIM   = mode_t'(1) << MB_DIM;
  localparam mode_t MODE_FAULT = mode_t'(1) << MB_FAULT;

  typedef enum logic [1:0] {
    REF_NONE    = 2'd0,
    REF_PREHEAT = 2'd1,
    REF_LIMIT   = 2'd2
  } ref_sel_e;
endpackage

// File: rtl/bms_flag_filter.sv
module bms_flag_filter #(
  parameter int WIDTH  = 12,
  parameter int STABLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] filt_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STABLE-1:0] hist_q;
    logic [STABLE:0]   shift_w;
    logic              q;

    assign shift_w = {hist_q, raw_i[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= '0;
        q      <= 1'b0;
      end else begin
        hist_q <= shift_w[STABLE-1:0];
        // accept the sampled value only when every stage agrees
        if (&hist_q)       q <= 1'b1;
        else if (~|hist_q) q <= 1'b0;
      end
    end

    assign filt_o[i] = q;
  end
endmodule

// File: rtl/bms_ign_detect.sv
module bms_ign_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic in_ign_i,
  input  logic above_arm_i,
  input  logic above_det_i,
  output logic armed_o,
  output logic declare_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed_q <= 1'b0;
    else if (!in_ign_i)   armed_q <= 1'b0;
    else if (above_arm_i) armed_q <= 1'b1;
  end

  assign armed_o   = armed_q;
  assign declare_o = in_ign_i & armed_q & ~above_det_i;
endmodule

// File: rtl/bms_mode_fsm.sv
module bms_mode_fsm
  import bms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_start,
  input  logic       vcc_stop,
  input  logic       bus_good,
  input  logic       bus_low,
  input  logic       sd_high,
  input  logic       sd_low,
  input  logic       over_temp,
  input  logic       cur_limit,
  input  logic       cur_ph,
  input  logic       tmr_done,
  input  logic       ign_declare,
  output mode_t      mode,
  output logic       bridge_en,
  output logic       timer_rst,
  output logic [1:0] ref_sel,
  output logic       ocp_en,
  output logic       pk_raise
);
  mode_t    state_q, state_d;
  ref_sel_e ref_w;
  logic     run_abort, start_ok, run_fault, fault_exit;

  assign run_abort  = vcc_stop | bus_low | sd_high;
  assign start_ok   = vcc_start & bus_good & sd_low & ~over_temp;
  assign run_fault  = cur_limit | over_temp;
  assign fault_exit = vcc_stop | sd_high;

  always_comb begin
    state_d = state_q;
    case (state_q)
      MODE_LOCK:  if (start_ok) state_d = MODE_PH;
      MODE_PH: begin
        if (run_abort)      state_d = MODE_LOCK;
        else if (over_temp) state_d = MODE_FAULT;
        else if (tmr_done)  state_d = MODE_IGN;
      end
      MODE_IGN: begin
        if (run_abort)        state_d = MODE_LOCK;
        else if (run_fault)   state_d = MODE_FAULT;
        else if (ign_declare) state_d = MODE_DIM;
      end
      MODE_DIM: begin
        if (run_abort)      state_d = MODE_LOCK;
        else if (run_fault) state_d = MODE_FAULT;
      end
      MODE_FAULT: if (fault_exit) state_d = MODE_LOCK;
      default:    state_d = MODE_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_LOCK;
    else        state_q <= state_d;
  end

  always_comb begin
    if (state_q[MB_PH])                        ref_w = REF_PREHEAT;
    else if (state_q[MB_IGN] | state_q[MB_DIM]) ref_w = REF_LIMIT;
    else                                        ref_w = REF_NONE;
  end

  assign mode      = state_q;
  assign bridge_en = state_q[MB_PH] | state_q[MB_IGN] | state_q[MB_DIM];
  assign timer_rst = state_q[MB_LOCK] | state_q[MB_FAULT];
  assign ref_sel   = ref_w;
  assign ocp_en    = state_q[MB_IGN] | state_q[MB_DIM];
  assign pk_raise  = state_q[MB_PH] & cur_ph;
endmodule

// File: rtl/ballast_mode_seq.sv
module ballast_mode_seq
  import bms_pkg::*;
#(
  parameter int STABLE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_start_i,
  input  logic       vcc_stop_i,
  input  logic       bus_good_i,
  input  logic       bus_low_i,
  input  logic       sd_high_i,
  input  logic       sd_low_i,
  input  logic       over_temp_i,
  input  logic       cur_limit_i,
  input  logic       cur_ph_i,
  input  logic       cur_arm_i,
  input  logic       cur_det_i,
  input  logic       tmr_done_i,
  output logic [4:0] mode_o,
  output logic       bridge_en_o,
  output logic       timer_rst_o,
  output logic [1:0] cur_ref_sel_o,
  output logic       ocp_en_o,
  output logic       pk_raise_o,
  output logic       det_ref_low_o
);
  logic [NUM_FLAGS-1:0] raw_flags, filt_flags;
  mode_t                mode_w;
  logic                 ign_declare;

  assign raw_flags[FL_VCC_START] = vcc_start_i;
  assign raw_flags[FL_VCC_STOP]  = vcc_stop_i;
  assign raw_flags[FL_BUS_GOOD]  = bus_good_i;
  assign raw_flags[FL_BUS_LOW]   = bus_low_i;
  assign raw_flags[FL_SD_HIGH]   = sd_high_i;
  assign raw_flags[FL_SD_LOW]    = sd_low_i;
  assign raw_flags[FL_OVER_TEMP] = over_temp_i;
  assign raw_flags[FL_CUR_LIMIT] = cur_limit_i;
  assign raw_flags[FL_CUR_PH]    = cur_ph_i;
  assign raw_flags[FL_CUR_ARM]   = cur_arm_i;
  assign raw_flags[FL_CUR_DET]   = cur_det_i;
  assign raw_flags[FL_TMR_DONE]  = tmr_done_i;

  bms_flag_filter #(.WIDTH(NUM_FLAGS), .STABLE(STABLE_CYCLES)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_flags),
    .filt_o (filt_flags)
  );

  bms_ign_detect u_ign (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ign_i    (mode_w[MB_IGN]),
    .above_arm_i (filt_flags[FL_CUR_ARM]),
    .above_det_i (filt_flags[FL_CUR_DET]),
    .armed_o     (det_ref_low_o),
    .declare_o   (ign_declare)
  );

  bms_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .vcc_start   (filt_flags[FL_VCC_START]),
    .vcc_stop    (filt_flags[FL_VCC_STOP]),
    .bus_good    (filt_flags[FL_BUS_GOOD]),
    .bus_low     (filt_flags[FL_BUS_LOW]),
    .sd_high     (filt_flags[FL_SD_HIGH]),
    .sd_low      (filt_flags[FL_SD_LOW]),
    .over_temp   (filt_flags[FL_OVER_TEMP]),
    .cur_limit   (filt_flags[FL_CUR_LIMIT]),
    .cur_ph      (filt_flags[FL_CUR_PH]),
    .tmr_done    (filt_flags[FL_TMR_DONE]),
    .ign_declare (ign_declare),
    .mode        (mode_w),
    .bridge_en   (bridge_en_o),
    .timer_rst   (timer_rst_o),
    .ref_sel     (cur_ref_sel_o),
    .ocp_en      (ocp_en_o),
    .pk_raise    (pk_raise_o)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/bms_checker.sv
module bms_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  mode,
  input logic        det_low,
  input logic [11:0] raw,
  input logic [11:0] filt
);
  // R12: mode register stays one-hot
  p_mode_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mode));

  // R2 / R10: preheat is entered only from lockout
  p_ph_from_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[1]) |-> $past(mode[0]));

  // R7: dim is entered only from an armed ignition
  p_dim_after_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[3]) |-> ($past(mode[2]) && $past(det_low)));

  // R9: fault is left only towards lockout
  p_fault_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode[4] |=> (mode[4] || mode[0]));

  // R8: fault is never entered from lockout
  p_fault_not_from_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[4]) |-> !$past(mode[0]));

  // R11: a filtered bit only changes to a value the raw bit held on two
  // consecutive sampled edges (depth fixed for the two-stage filter)
  p_filter_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ $past(filt)) & ((filt ^ $past(raw, 2)) | (filt ^ $past(raw, 3)))) == 12'h000);
endmodule

bind ballast_mode_seq bms_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode_o),
  .det_low (det_ref_low_o),
  .raw     (raw_flags),
  .filt    (filt_flags)
);

// File: tb/ballast_mode_seq_bench.sv
`timescale 1ns/1ps
module ballast_mode_seq_bench;
  localparam logic [11:0] F_START = 12'h001, F_STOP = 12'h002, F_GOOD = 12'h004,
                          F_BLOW  = 12'h008, F_SDH  = 12'h010, F_SDL  = 12'h020,
                          F_OT    = 12'h040, F_LIM  = 12'h080, F_CPH  = 12'h100,
                          F_ARM   = 12'h200, F_DET  = 12'h400, F_TMR  = 12'h800;
  localparam logic [11:0] F_OK = F_START | F_GOOD | F_SDL;
  localparam logic [4:0]  M_LOCK = 5'b00001, M_PH = 5'b00010, M_IGN = 5'b00100,
                          M_DIM  = 5'b01000, M_FLT = 5'b10000;
  localparam int ROWS = 44;
  // {flags, expected mode, expected detect-low}
  localparam logic [17:0] VEC [ROWS] = '{
    {12'h000, M_LOCK, 1'b0},                        // 0  R1
    {F_START | F_GOOD, M_LOCK, 1'b0},               // 1  R2
    {F_OK | F_OT, M_LOCK, 1'b0},                    // 2  R2
    {F_START | F_SDL | F_BLOW, M_LOCK, 1'b0},       // 3  R2
    {F_OK, M_PH, 1'b0},                             // 4  R2
    {F_OK | F_LIM | F_CPH, M_PH, 1'b0},             // 5  R5
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 6  R5
    {F_OK | F_TMR | F_DET, M_IGN, 1'b0},            // 7  R7
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 8  R7
    {F_OK | F_TMR | F_ARM | F_DET, M_IGN, 1'b1},    // 9  R7
    {F_OK | F_TMR | F_DET, M_IGN, 1'b1},            // 10 R7
    {F_OK | F_TMR, M_DIM, 1'b0},                    // 11 R7
    {F_OK | F_TMR | F_CPH, M_DIM, 1'b0},            // 12 R5
    {F_OK | F_TMR | F_LIM, M_FLT, 1'b0},            // 13 R8
    {F_OK | F_TMR, M_FLT, 1'b0},                    // 14 R9
    {F_START | F_BLOW | F_SDL | F_TMR, M_FLT, 1'b0},// 15 R9
    {F_START | F_GOOD | F_SDH | F_TMR, M_LOCK, 1'b0},// 16 R9
    {F_OK, M_PH, 1'b0},                             // 17 R10
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 18 R5
    {F_OK | F_TMR | F_LIM, M_FLT, 1'b0},            // 19 R6
    {F_STOP | F_GOOD | F_SDL, M_LOCK, 1'b0},        // 20 R9
    {F_OK, M_PH, 1'b0},                             // 21 R10
    {F_START | F_SDL | F_BLOW, M_LOCK, 1'b0},       // 22 R3
    {F_OK, M_PH, 1'b0},                             // 23
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 24
    {F_OK | F_TMR | F_OT, M_FLT, 1'b0},             // 25 R6
    {F_START | F_GOOD | F_SDH, M_LOCK, 1'b0},       // 26 R9
    {F_OK, M_PH, 1'b0},                             // 27
    {F_OK | F_OT, M_FLT, 1'b0},                     // 28 R8
    {F_STOP | F_GOOD | F_SDL, M_LOCK, 1'b0},        // 29 R9
    {F_OK, M_PH, 1'b0},                             // 30
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 31
    {F_START | F_GOOD | F_SDH | F_TMR, M_LOCK, 1'b0},// 32 R3
    {F_OK, M_PH, 1'b0},                             // 33
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 34
    {F_OK | F_TMR | F_ARM | F_DET, M_IGN, 1'b1},    // 35
    {F_OK | F_TMR, M_DIM, 1'b0},                    // 36
    {F_OK | F_TMR | F_OT, M_FLT, 1'b0},             // 37 R8
    {F_START | F_GOOD | F_SDH, M_LOCK, 1'b0},       // 38 R9
    {F_OK, M_PH, 1'b0},                             // 39
    {F_OK | F_TMR, M_IGN, 1'b0},                    // 40
    {F_OK | F_TMR | F_ARM | F_DET, M_IGN, 1'b1},    // 41
    {F_OK | F_TMR, M_DIM, 1'b0},                    // 42
    {F_STOP | F_GOOD | F_SDL | F_TMR | F_LIM, M_LOCK, 1'b0} // 43 R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] flags = 12'h000;
  logic [4:0]  mode_o;
  logic        bridge_en_o, timer_rst_o, ocp_en_o, pk_raise_o, det_ref_low_o;
  logic [1:0]  cur_ref_sel_o;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  ballast_mode_seq u_ballast_mode_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_start_i   (flags[0]),
    .vcc_stop_i    (flags[1]),
    .bus_good_i    (flags[2]),
    .bus_low_i     (flags[3]),
    .sd_high_i     (flags[4]),
    .sd_low_i      (flags[5]),
    .over_temp_i   (flags[6]),
    .cur_limit_i   (flags[7]),
    .cur_ph_i      (flags[8]),
    .cur_arm_i     (flags[9]),
    .cur_det_i     (flags[10]),
    .tmr_done_i    (flags[11]),
    .mode_o        (mode_o),
    .bridge_en_o   (bridge_en_o),
    .timer_rst_o   (timer_rst_o),
    .cur_ref_sel_o (cur_ref_sel_o),
    .ocp_en_o      (ocp_en_o),
    .pk_raise_o    (pk_raise_o),
    .det_ref_low_o (det_ref_low_o)
  );

  function automatic string req_of(input int row);
    case (row)
      0:                              return "R1";
      1, 2, 3, 4:                     return "R2";
      5, 6, 12, 18:                   return "R5";
      7, 8, 9, 10, 11:                return "R7";
      13, 28, 37:                     return "R8";
      19, 25:                         return "R6";
      14, 15, 16, 20, 26, 29, 38:     return "R9";
      17, 21:                         return "R10";
      22, 32, 43:                     return "R3";
      default:                        return "R4";
    endcase
  endfunction

  // Expected outputs derived from the mode per R4/R5/R7
  task automatic check(input string req, input logic [4:0] m_exp,
                       input logic pk_exp, input logic det_exp);
    logic [11:0] act, expv;
    logic        br, tr, oc;
    logic [1:0]  rf;
    br = m_exp[1] | m_exp[2] | m_exp[3];
    tr = m_exp[0] | m_exp[4];
    rf = m_exp[1] ? 2'd1 : ((m_exp[2] | m_exp[3]) ? 2'd2 : 2'd0);
    oc = m_exp[2] | m_exp[3];
    expv = {m_exp, br, tr, rf, oc, pk_exp, det_exp};
    act  = {mode_o, bridge_en_o, timer_rst_o, cur_ref_sel_o, ocp_en_o, pk_raise_o, det_ref_low_o};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] v;
    logic [4:0]  m;
    // R1: state during reset
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", M_LOCK, 1'b0, 1'b0);
    rst_n = 1'b1;
    settle(2);
    check("R1", M_LOCK, 1'b0, 1'b0);

    // Vector table
    for (int r = 0; r < ROWS; r++) begin
      v = VEC[r];
      m = v[5:1];
      @(negedge clk);
      flags = v[17:6];
      settle(6);
      check(req_of(r), m, (m == M_PH) && flags[8], v[0]);
      checks++;
      if (!$onehot(mode_o)) begin
        fails++;
        $display("FAIL R12: actual %b expected one-hot", mode_o);
      end
    end

    // R11: exact latency, mode moves on the fourth rising edge
    @(negedge clk);
    flags = 12'h000;
    settle(6);
    flags = F_OK;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", M_LOCK, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R11", M_PH, 1'b0, 1'b0);

    // R11: one-cycle timer pulse ignored
    flags = F_OK | F_TMR;
    @(negedge clk);
    flags = F_OK;
    settle(8);
    check("R11", M_PH, 1'b0, 1'b0);

    // R11: two-cycle timer pulse accepted
    flags = F_OK | F_TMR;
    @(negedge clk);
    @(negedge clk);
    flags = F_OK;
    settle(8);
    check("R11", M_IGN, 1'b0, 1'b0);

    // R6 then R9: one-cycle shutdown pulse does not release fault
    flags = F_OK | F_LIM;
    settle(6);
    check("R6", M_FLT, 1'b0, 1'b0);
    flags = F_START | F_GOOD | F_SDH;
    @(negedge clk);
    flags = F_OK;
    settle(8);
    check("R9", M_FLT, 1'b0, 1'b0);

    // R1: asynchronous reset from fault
    rst_n = 1'b0;
    #1;
    check("R1", M_LOCK, 1'b0, 1'b0);
    settle(3);
    rst_n = 1'b1;
    settle(8);
    check("R2", M_PH, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule